// File: doc/BRIEF.md
# Selectable-Source Module Clock Divider

This block derives a module clock from one of several source clocks. It lives entirely in one fast reference clock domain. Each source arrives as a one-cycle tick on its own bit of a tick vector. A 32-bit control word picks the source, sets a power-of-two pre-divider and a linear divider, and gates the output. The output is a registered, 50%-duty divided clock. A one-cycle strobe marks each of its rising edges.

Software writes the control word through a plain write strobe and reads it back on a read bus. New divider or source settings are held back until the current output period has finished. As a result, a change never produces a shortened pulse. A build parameter widens the source-select field from 2 to 4 bits. A second parameter builds a variant whose output cannot be stopped.

Top module: `modclk_gen`

## Requirements
- R1: Each half period of `mclk_out` lasts exactly (M+1)·2^P ticks of the selected source. M is control bits 3:0 and P is control bits 17:16. The output changes only on a cycle in which the selected source ticked, so it is never faster than that source.
- R2: With P=0 and M=0, the output inverts on every selected tick.
- R3: The selected source index is the field starting at bit 24, which is SEL_W bits wide (2 by default, 4 in the wide build). Ticks on any other source are ignored.
- R4: When bit 31 is clear, the output finishes its current high half and then stays low, ignoring ticks. Disabling during a low half stops at once and clears the count, so a later enable starts a fresh period.
- R5: With ALWAYS_ON=1, bit 31 has no effect and the output runs whenever the selected source ticks.
- R6: `mclk_rise` is high for exactly the one cycle in which `mclk_out` has just risen, and is low otherwise.
- R7: A write that changes M, P or the source during a period takes effect only after the next falling edge of the output. A write made while the output is low and at a period boundary, or idle, takes effect on the next tick.
- R8: Control bits outside bit 31, the select field, bits 17:16 and bits 3:0 ignore writes and read back as zero. All-ones reads 32'h8303000F when SEL_W=2 and 32'h8F03000F when SEL_W=4.
- R9: After reset the control word reads zero and both `mclk_out` and `mclk_rise` are low.
- R10: `mclk_out` and `mclk_rise` are registered. They change at the same clock edge that samples the deciding tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 2^SEL_W | One clock-enable tick per source |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control word, undefined bits zero |
| mclk_out | output | 1 | Divided module clock |
| mclk_rise | output | 1 | One-cycle strobe on each rising edge of `mclk_out` |

## Verification
The bench sweeps divider and source settings, from divide-by-one up to the largest pre-divide with the largest linear divide. It counts selected ticks per half period, so a counter compare that is off by one shows up as a wrong count. Non-selected sources tick between selected ticks, which catches a mux that decodes the wrong field. A mid-period divider write checks that the old setting finishes its half period; a design that applied it at once would fall early. Disable tests, in both the high and the low half, catch an output that is cut short or that resumes from a stale count. The always-on build is driven with the enable bit clear to show that the gate is really ignored.

// File: rtl/modclk_pkg.sv
package modclk_pkg;

  localparam int CTRL_W   = 32;
  localparam int LDIV_LSB = 0;
  localparam int LDIV_W   = 4;
  localparam int PDIV_LSB = 16;
  localparam int PDIV_W   = 2;
  localparam int SRC_LSB  = 24;
  localparam int SRC_MAXW = 4;
  localparam int GATE_BIT = 31;
  localparam int PCNT_W   = (1 << PDIV_W) - 1;

  typedef struct packed {
    logic [SRC_MAXW-1:0] src;
    logic [PDIV_W-1:0]   pdiv;
    logic [LDIV_W-1:0]   ldiv;
  } mcfg_t;

  function automatic logic [CTRL_W-1:0] ctrl_mask(input int sel_w);
    logic [CTRL_W-1:0] mk;
    mk = '0;
    mk[GATE_BIT] = 1'b1;
    for (int i = 0; i < sel_w; i++) mk[SRC_LSB+i] = 1'b1;
    for (int i = 0; i < PDIV_W; i++) mk[PDIV_LSB+i] = 1'b1;
    for (int i = 0; i < LDIV_W; i++) mk[LDIV_LSB+i] = 1'b1;
    return mk;
  endfunction

  function automatic mcfg_t unpack_cfg(input logic [CTRL_W-1:0] w);
    mcfg_t c;
    c.src  = w[SRC_LSB  +: SRC_MAXW];
    c.pdiv = w[PDIV_LSB +: PDIV_W];
    c.ldiv = w[LDIV_LSB +: LDIV_W];
    return c;
  endfunction

  function automatic logic [PCNT_W-1:0] pre_last(input logic [PDIV_W-1:0] p);
    logic [PCNT_W-1:0] v;
    v = '0;
    for (int i = 0; i < PCNT_W; i++) v[i] = (i < int'(p));
    return v;
  endfunction

  function automatic int half_ticks(input logic [PDIV_W-1:0] p, input logic [LDIV_W-1:0] m);
    return (int'(m) + 1) << int'(p);
  endfunction

endpackage

// File: rtl/modclk_regs.sv
module modclk_regs
  import modclk_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] ctrl_q
);
  localparam logic [CTRL_W-1:0] MASK = ctrl_mask(SEL_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wr_data & MASK;
  end
endmodule

// File: rtl/modclk_cfg.sv
module modclk_cfg
  import modclk_pkg::*;
#(
  parameter int SEL_W = 2,
  localparam int NSRC = 1 << SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_q,
  input  logic              at_bound,
  input  logic              take,
  input  logic [NSRC-1:0]   src_tick,
  output mcfg_t             cfg_eff,
  output mcfg_t             cfg_act,
  output logic              tick_sel
);
  mcfg_t cfg_new;
  logic [SEL_W-1:0] src_idx;

  assign cfg_new = unpack_cfg(ctrl_q);
  assign cfg_eff = at_bound ? cfg_new : cfg_act;
  assign src_idx = cfg_eff.src[SEL_W-1:0];

  generate
    if (SEL_W < SRC_MAXW) begin : g_pad
      logic unused_hi;
      assign unused_hi = ^cfg_eff.src[SRC_MAXW-1:SEL_W];
    end
  endgenerate

  assign tick_sel = src_tick[src_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_act <= '0;
    else if (take) cfg_act <= cfg_new;
  end
endmodule

// File: rtl/modclk_div.sv
module modclk_div
  import modclk_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mcfg_t cfg_eff,
  input  logic  tick_sel,
  input  logic  run_en,
  output logic  mclk_out,
  output logic  mclk_rise,
  output logic  at_bound,
  output logic  take,
  output logic  period_end
);
  logic [PCNT_W-1:0] pcnt;
  logic [LDIV_W-1:0] mcnt;
  logic count_ok, pre_hit, hit, stop_now;

  assign count_ok   = tick_sel & (run_en | mclk_out);
  assign pre_hit    = count_ok & (pcnt == pre_last(cfg_eff.pdiv));
  assign hit        = pre_hit & (mcnt == cfg_eff.ldiv);
  assign take       = count_ok & at_bound;
  assign period_end = hit & mclk_out;
  assign stop_now   = !run_en && !mclk_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt      <= '0;
      mcnt      <= '0;
      mclk_out  <= 1'b0;
      mclk_rise <= 1'b0;
      at_bound  <= 1'b1;
    end else begin
      mclk_rise <= 1'b0;
      if (stop_now) begin
        pcnt     <= '0;
        mcnt     <= '0;
        at_bound <= 1'b1;
      end else if (count_ok) begin
        pcnt     <= pre_hit ? '0 : pcnt + 1'b1;
        if (pre_hit) mcnt <= hit ? '0 : mcnt + 1'b1;
        at_bound <= period_end;
        if (hit) begin
          mclk_out  <= ~mclk_out;
          mclk_rise <= ~mclk_out;
        end
      end
    end
  end
endmodule

// File: rtl/modclk_gen.sv
module modclk_gen
  import modclk_pkg::*;
#(
  parameter int SEL_W     = 2,
  parameter bit ALWAYS_ON = 1'b0,
  localparam int NSRC     = 1 << SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_tick,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] rd_data,
  output logic              mclk_out,
  output logic              mclk_rise
);
  logic [CTRL_W-1:0] ctrl_q;
  mcfg_t cfg_eff, cfg_act;
  logic tick_sel, at_bound, take, period_end, run_en;

  modclk_regs #(.SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .ctrl_q(ctrl_q)
  );

  generate
    if (ALWAYS_ON) begin : g_free
      assign run_en = 1'b1;
    end else begin : g_gated
      assign run_en = ctrl_q[GATE_BIT];
    end
  endgenerate

  modclk_cfg #(.SEL_W(SEL_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .at_bound(at_bound), .take(take),
    .src_tick(src_tick), .cfg_eff(cfg_eff), .cfg_act(cfg_act), .tick_sel(tick_sel)
  );

  modclk_div u_div (
    .clk(clk), .rst_n(rst_n), .cfg_eff(cfg_eff), .tick_sel(tick_sel), .run_en(run_en),
    .mclk_out(mclk_out), .mclk_rise(mclk_rise), .at_bound(at_bound), .take(take),
    .period_end(period_end)
  );

  assign rd_data = ctrl_q;
endmodule

// File: rtl/modclk_chk.sv
module modclk_chk
  import modclk_pkg::*;
#(
  parameter int SEL_W     = 2,
  parameter bit ALWAYS_ON = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CTRL_W-1:0] rd_data,
  input logic              mclk_out,
  input logic              mclk_rise,
  input logic              tick_sel,
  input logic              at_bound,
  input logic              period_end,
  input mcfg_t             cfg_act
);
  localparam logic [CTRL_W-1:0] MASK = ctrl_mask(SEL_W);

  AST_TOGGLE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (mclk_out != $past(mclk_out)) |-> $past(tick_sel)); // R1

  AST_RISE_MARKS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mclk_out) |-> mclk_rise); // R6

  AST_RISE_ONLY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    mclk_rise |-> mclk_out); // R6

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mclk_rise |=> !mclk_rise); // R6

  AST_GATE_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!ALWAYS_ON && !rd_data[GATE_BIT] && !mclk_out) |=> !mclk_out); // R4

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !at_bound |=> $stable(cfg_act)); // R7

  AST_END_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> (!mclk_out && at_bound)); // R7

  AST_RDBACK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~MASK) == '0); // R8
endmodule

bind modclk_gen modclk_chk #(.SEL_W(SEL_W), .ALWAYS_ON(ALWAYS_ON)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .mclk_out(mclk_out),
  .mclk_rise(mclk_rise), .tick_sel(tick_sel), .at_bound(at_bound),
  .period_end(period_end), .cfg_act(cfg_act)
);

// File: tb/sim_modclk_gen.sv
`timescale 1ns/1ps
module sim_modclk_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0]  src0 = '0;
  logic [15:0] src1 = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd0, rd1;
  logic mo0, mr0, mo1, mr1;
  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;
  bit other_bad;

  always #4 clk = ~clk;

  modclk_gen #(.SEL_W(2), .ALWAYS_ON(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .src_tick(src0), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd0), .mclk_out(mo0), .mclk_rise(mr0));

  modclk_gen #(.SEL_W(4), .ALWAYS_ON(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .src_tick(src1), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd1), .mclk_out(mo1), .mclk_rise(mr1));

  typedef struct packed { logic [1:0] p; logic [3:0] m; logic [1:0] sel; } vec_t;
  localparam vec_t VECS [8] = '{
    '{2'd0, 4'd0,  2'd0}, '{2'd0, 4'd3,  2'd1}, '{2'd1, 4'd0,  2'd2}, '{2'd2, 4'd5,  2'd3},
    '{2'd3, 4'd15, 2'd1}, '{2'd1, 4'd7,  2'd0}, '{2'd3, 4'd0,  2'd2}, '{2'd0, 4'd15, 2'd3}};

  function automatic logic [31:0] word(input bit en, input int sel, input int p, input int m);
    return {en, 31'd0} | (32'(sel) << 24) | (32'(p) << 16) | 32'(m);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] s0, input logic [15:0] s1);
    @(negedge clk);
    wr_en = 1'b0; src0 = s0; src1 = s1;
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; src0 = '0; src1 = '0;
    @(posedge clk); #1;
  endtask

  task automatic tick_until(input int sel, input logic want, output int n, output logic rs);
    n = 0;
    while (mo0 !== want && n < 400) begin
      logic prev;
      prev = mo0;
      step(4'hF & ~(4'b1 << sel), 16'h0);
      if (mo0 !== prev) other_bad = 1'b1;
      step(4'b1 << sel, 16'h0);
      n++;
    end
    rs = mr0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int n, exp;
    logic rs;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset ctrl", rd0, 32'h0);
    chk("R9 reset out", {mr0, mo0}, 2'b00);
    @(negedge clk); rst_n = 1'b1;

    wr(32'hFFFF_FFFF);
    chk("R8 readback narrow", rd0, 32'h8303_000F);
    chk("R8 readback wide", rd1, 32'h8F03_000F);
    wr(32'h0);
    chk("R8 cleared", rd0, 32'h0);

    for (int v = 0; v < 8; v++) begin
      exp = (int'(VECS[v].m) + 1) << VECS[v].p;
      other_bad = 1'b0;
      wr(word(1'b1, VECS[v].sel, VECS[v].p, VECS[v].m));
      tick_until(VECS[v].sel, 1'b1, n, rs);
      chk("R1 first low half", n, exp);
      chk("R6 rise strobe", rs, 1'b1);
      step(4'h0, 16'h0);
      chk("R6 rise one cycle", mr0, 1'b0);
      tick_until(VECS[v].sel, 1'b0, n, rs);
      chk("R1 high half", n, exp);
      tick_until(VECS[v].sel, 1'b1, n, rs);
      chk("R1 second low half", n, exp);
      tick_until(VECS[v].sel, 1'b0, n, rs);
      chk("R3 other sources ignored", other_bad, 1'b0);
    end

    // R2 divide-by-one: toggles on each tick, R10 on the sampling edge
    wr(word(1'b1, 0, 0, 0));
    step(4'b0001, 16'h0);
    chk("R2 R10 toggle high", mo0, 1'b1);
    step(4'b0001, 16'h0);
    chk("R2 toggle low", mo0, 1'b0);

    // R7 mid-period change waits for the falling edge
    wr(word(1'b1, 0, 0, 3));
    tick_until(0, 1'b1, n, rs);
    chk("R7 old setting rise", n, 4);
    step(4'b0001, 16'h0);
    wr(word(1'b1, 0, 0, 0));
    step(4'b0001, 16'h0);
    step(4'b0001, 16'h0);
    chk("R7 still high", mo0, 1'b1);
    step(4'b0001, 16'h0);
    chk("R7 old half finishes", mo0, 1'b0);
    step(4'b0001, 16'h0);
    chk("R7 new setting used", mo0, 1'b1);
    step(4'b0001, 16'h0);

    // R4 disable during high half
    wr(word(1'b1, 0, 0, 1));
    tick_until(0, 1'b1, n, rs);
    wr(word(1'b0, 0, 0, 1));
    step(4'b0001, 16'h0);
    chk("R4 high half completes", mo0, 1'b1);
    step(4'b0001, 16'h0);
    chk("R4 falls at end", mo0, 1'b0);
    for (int k = 0; k < 5; k++) step(4'b0001, 16'h0);
    chk("R4 held low", mo0, 1'b0);

    // R4 disable during low half, then fresh restart
    wr(word(1'b1, 0, 0, 1));
    step(4'b0001, 16'h0);
    wr(word(1'b0, 0, 0, 1));
    for (int k = 0; k < 4; k++) step(4'b0001, 16'h0);
    chk("R4 low stop", mo0, 1'b0);
    wr(word(1'b1, 0, 0, 1));
    tick_until(0, 1'b1, n, rs);
    chk("R4 restart count", n, 2);
    tick_until(0, 1'b0, n, rs);

    // R5 always-on build ignores the gate bit; wide select (R3)
    wr(word(1'b0, 9, 0, 0));
    step(4'b0010, 16'h0002);
    chk("R5 wide R3 unselected", mo1, 1'b0);
    chk("R4 gated stays low", mo0, 1'b0);
    step(4'h0, 16'h0200);
    chk("R5 runs with gate clear", {mr1, mo1}, 2'b11);
    step(4'h0, 16'h0200);
    chk("R5 toggles back", mo1, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule